// File: doc/BRIEF.md
# Bus wait-state controller

This block stands between a CPU request port and a set of memory and I/O regions on a 24-bit linear address space of 16 MB. Each accepted access is decoded into one of three regions: program memory, the I/O port area, or everything else. The block then looks up the region's wait-state and hold-state counts and sequences the slave strobe, the data-valid flag and the CPU ready pulse over the required cycles.

Program memory and the I/O port area each have a timing register with its own wait count (0 to 7 extra strobe cycles) and hold count (0 to 3 idle cycles after the access). A small write-only register port sets these counts. Both registers come out of reset at the slowest setting, so software must program faster values once it knows the clock rate. The remaining region always runs with no wait and no hold. Transfers are byte-wide or word-wide (16 bits), reads or writes.

A request is taken only in a cycle where `cpu_idle` is high. The access parameters and timing are captured at that edge, so a later change to a timing register cannot disturb an access that is already in flight.

Top module: `bus_wait_ctrl`

## Requirements
- R1: Addresses 0x000000 to 0x03FFFF decode to program memory (`bus_sel` bit 0), 0xFF0000 to 0xFFFFFF to the I/O port area (bit 1), and all others to the general region (bit 2). During strobe cycles `bus_sel` is one-hot; otherwise it is zero.
- R2: A request sampled with `cpu_idle` high starts an access. `bus_strb` is high from the next cycle for W+1 consecutive cycles, where W is the region's wait count. The general region uses W=0.
- R3: `cpu_ready` and `bus_dvalid` are high together for exactly one cycle, the last strobe cycle of each access.
- R4: After the last strobe cycle, H hold cycles follow with `bus_strb` low and `cpu_idle` low, where H is the region's hold count (0 for the general region). Then `cpu_idle` returns high.
- R5: A write with `cfg_wr` high and `cfg_sel`=0 sets the program-memory timing; `cfg_sel`=1 sets the I/O timing. `cfg_wdata[2:0]` is the wait count and `cfg_wdata[4:3]` is the hold count. Writes with `cfg_sel` of 2 or 3 have no effect.
- R6: After reset, `cpu_idle` is high, `bus_strb` is low, and both timing registers hold wait 7 and hold 3.
- R7: A timing write affects only accesses accepted at a later edge. An access accepted at the same edge as the write uses the old counts.
- R8: A byte access (`cpu_word`=0) drives the full address. `bus_be` is 2'b01 for an even address and 2'b10 for an odd one. `bus_wdata` carries the write byte on both lanes. A byte read returns the selected lane, zero-extended, on `cpu_rdata`.
- R9: A word access drives `bus_be`=2'b11 and forces `bus_addr[0]` to 0. A word read returns all 16 bits of `bus_rdata`.
- R10: `bus_addr`, `bus_be`, `bus_we` and `bus_wdata` stay constant over all strobe cycles of one access.
- R11: `cpu_req` is ignored while `cpu_idle` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Timing register write strobe |
| cfg_sel | input | 2 | Timing register select: 0 program memory, 1 I/O |
| cfg_wdata | input | 5 | [4:3] hold count, [2:0] wait count |
| cpu_req | input | 1 | Access request, sampled while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 16 | Write data (byte in [7:0]) |
| cpu_idle | output | 1 | Controller can accept a request |
| cpu_ready | output | 1 | One-cycle access completion |
| cpu_rdata | output | 16 | Read data, valid with `cpu_ready` on reads |
| bus_sel | output | 3 | One-hot region select during strobe |
| bus_strb | output | 1 | Slave access strobe |
| bus_we | output | 1 | Slave write enable, gated by strobe |
| bus_be | output | 2 | Byte lane enables, gated by strobe |
| bus_addr | output | 24 | Slave address |
| bus_wdata | output | 16 | Slave write data |
| bus_dvalid | output | 1 | Read data sampled / write committed this cycle |
| bus_rdata | input | 16 | Slave read data |

## Verification
The assertions assume that `bus_rdata` is a function of the presented address and that requests arrive only through the idle handshake. They make no assumption about when `cpu_req` rises, because the design must ignore it while busy. The stimulus holds `cpu_req` high with a different address through whole busy periods to exercise that case. It changes inputs only away from the clock edge, and writes the timing registers in the same cycle as a request to probe the capture edge. A behavioural model in the bench decodes the region, counts wait and hold cycles from its own copy of the timing settings, and predicts every output each cycle.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    localparam int ADDR_W    = 24;
    localparam int DATA_W    = 16;
    localparam int LANE_W    = DATA_W / 2;
    localparam int WAIT_W    = 3;
    localparam int HOLD_W    = 2;
    localparam int CFG_W     = WAIT_W + HOLD_W;
    localparam int CFG_SEL_W = 2;
    localparam int N_REGION  = 3;
    localparam int N_TIMED   = 2;

    typedef enum logic [1:0] {
        RG_PMEM  = 2'd0,
        RG_IO    = 2'd1,
        RG_OTHER = 2'd2
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_HOLD   = 2'd2
    } seq_state_e;

    // layout matches the register write word: hold above wait
    typedef struct packed {
        logic [HOLD_W-1:0] hold;
        logic [WAIT_W-1:0] wcnt;
    } timing_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic              word;
        logic [DATA_W-1:0] wdata;
        region_e           region;
    } access_t;

    function automatic timing_t timing_slowest();
        timing_t t;
        t.hold = '1;
        t.wcnt = '1;
        return t;
    endfunction

    function automatic logic [N_REGION-1:0] region_onehot(region_e r);
        return N_REGION'(1) << r;
    endfunction

    function automatic logic [1:0] lane_enables(logic odd, logic word);
        if (word) return 2'b11;
        return odd ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [DATA_W-1:0] lane_read(logic [DATA_W-1:0] d,
                                                     logic odd, logic word);
        if (word) return d;
        return {{LANE_W{1'b0}}, (odd ? d[DATA_W-1:LANE_W] : d[LANE_W-1:0])};
    endfunction

endpackage

// File: rtl/bwc_decode.sv
module bwc_decode
    import bwc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PMEM_BASE      = 24'h000000,
    parameter int                PMEM_SPAN_LOG2 = 18,
    parameter logic [ADDR_W-1:0] IO_BASE        = 24'hFF0000,
    parameter int                IO_SPAN_LOG2   = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    localparam logic [ADDR_W-1:0] PMEM_MASK =
        ~((ADDR_W'(1) << PMEM_SPAN_LOG2) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] IO_MASK =
        ~((ADDR_W'(1) << IO_SPAN_LOG2) - ADDR_W'(1));

    logic hit_pmem;
    logic hit_io;

    always_comb begin
        hit_pmem = ((addr ^ PMEM_BASE) & PMEM_MASK) == '0;
        hit_io   = ((addr ^ IO_BASE) & IO_MASK) == '0;
        if (hit_pmem)    region = RG_PMEM;
        else if (hit_io) region = RG_IO;
        else             region = RG_OTHER;
    end
endmodule

// File: rtl/bwc_timing_regs.sv
module bwc_timing_regs
    import bwc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [CFG_SEL_W-1:0] cfg_sel,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  region_e              region,
    output timing_t              timing
);
    timing_t regs_q [N_TIMED];

    for (genvar i = 0; i < N_TIMED; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[i] <= timing_slowest();
            end else if (cfg_wr && cfg_sel == CFG_SEL_W'(i)) begin
                regs_q[i] <= timing_t'(cfg_wdata);
            end
        end
    end

    // untimed regions run at zero wait, zero hold
    always_comb begin
        timing = '0;
        for (int i = 0; i < N_TIMED; i++) begin
            if (int'(region) == i) timing = regs_q[i];
        end
    end
endmodule

// File: rtl/bwc_seq.sv
module bwc_seq
    import bwc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  access_t start_acc,
    input  timing_t start_tim,
    output logic    idle,
    output logic    strobe,
    output logic    last,
    output access_t cur
);
    seq_state_e         st;
    logic [WAIT_W-1:0]  cnt;
    logic [HOLD_W-1:0]  hold_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            hold_r <= '0;
            cur    <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        cur    <= start_acc;
                        cnt    <= start_tim.wcnt;
                        hold_r <= start_tim.hold;
                        st     <= ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    if (cnt == '0) begin
                        if (hold_r == '0) begin
                            st <= ST_IDLE;
                        end else begin
                            cnt <= WAIT_W'(hold_r) - 1'b1;
                            st  <= ST_HOLD;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (cnt == '0) st <= ST_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        idle   = (st == ST_IDLE);
        strobe = (st == ST_ACCESS);
        last   = strobe && (cnt == '0);
    end
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
    import bwc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [CFG_SEL_W-1:0] cfg_sel,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic                 cpu_word,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [DATA_W-1:0]    cpu_wdata,
    output logic                 cpu_idle,
    output logic                 cpu_ready,
    output logic [DATA_W-1:0]    cpu_rdata,
    output logic [N_REGION-1:0]  bus_sel,
    output logic                 bus_strb,
    output logic                 bus_we,
    output logic [1:0]           bus_be,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [DATA_W-1:0]    bus_wdata,
    output logic                 bus_dvalid,
    input  logic [DATA_W-1:0]    bus_rdata
);
    region_e req_region;
    timing_t req_tim;
    access_t req_acc;
    access_t cur;
    logic    seq_idle;
    logic    seq_strobe;
    logic    seq_last;

    bwc_decode u_dec (
        .addr   (cpu_addr),
        .region (req_region)
    );

    bwc_timing_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .region    (req_region),
        .timing    (req_tim)
    );

    always_comb begin
        req_acc.addr   = cpu_addr;
        req_acc.we     = cpu_we;
        req_acc.word   = cpu_word;
        req_acc.wdata  = cpu_wdata;
        req_acc.region = req_region;
    end

    bwc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (cpu_req),
        .start_acc (req_acc),
        .start_tim (req_tim),
        .idle      (seq_idle),
        .strobe    (seq_strobe),
        .last      (seq_last),
        .cur       (cur)
    );

    always_comb begin
        cpu_idle   = seq_idle;
        cpu_ready  = seq_last;
        bus_strb   = seq_strobe;
        bus_dvalid = seq_last;
        bus_sel    = seq_strobe ? region_onehot(cur.region) : '0;
        bus_we     = seq_strobe && cur.we;
        bus_be     = seq_strobe ? lane_enables(cur.addr[0], cur.word) : 2'b00;
        bus_addr   = cur.word ? {cur.addr[ADDR_W-1:1], 1'b0} : cur.addr;
        bus_wdata  = cur.word ? cur.wdata : {2{cur.wdata[LANE_W-1:0]}};
        cpu_rdata  = (seq_last && !cur.we)
                   ? lane_read(bus_rdata, cur.addr[0], cur.word) : '0;
    end
endmodule

// File: rtl/bwc_chk.sv
module bwc_chk
    import bwc_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                cpu_idle,
    input logic                cpu_ready,
    input logic [N_REGION-1:0] bus_sel,
    input logic                bus_strb,
    input logic                bus_we,
    input logic [1:0]          bus_be,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                bus_dvalid
);
    localparam int MAX_STROBE = 1 << WAIT_W;
    localparam int RUN_W      = WAIT_W + 1;

    logic [RUN_W-1:0] strb_run;

    always_ff @(posedge clk) begin
        if (rst) strb_run <= '0;
        else     strb_run <= bus_strb ? strb_run + 1'b1 : '0;
    end

    // R6
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cpu_idle && !bus_strb);

    // R3
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    // R3
    ready_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> bus_strb && bus_dvalid);

    // R2
    strobe_until_ready_chk: assert property (@(posedge clk) disable iff (rst)
        bus_strb && !cpu_ready |=> bus_strb);

    // R2
    max_wait_chk: assert property (@(posedge clk) disable iff (rst)
        bus_strb |-> strb_run < RUN_W'(MAX_STROBE));

    // R1
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        bus_strb |-> $countones(bus_sel) == 1);

    // R1
    sel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_strb |-> bus_sel == '0);

    // R10
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        bus_strb && !cpu_ready |=> $stable(bus_addr) && $stable(bus_be)
                                   && $stable(bus_we) && $stable(bus_wdata));

    // R9
    word_align_chk: assert property (@(posedge clk) disable iff (rst)
        bus_strb && bus_be == 2'b11 |-> !bus_addr[0]);

    // R8
    byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
        bus_strb && bus_be != 2'b11 |-> bus_be == (bus_addr[0] ? 2'b10 : 2'b01));

    // R11
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_idle |-> !bus_strb);
endmodule

bind bus_wait_ctrl bwc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_idle   (cpu_idle),
    .cpu_ready  (cpu_ready),
    .bus_sel    (bus_sel),
    .bus_strb   (bus_strb),
    .bus_we     (bus_we),
    .bus_be     (bus_be),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_dvalid (bus_dvalid)
);

// File: tb/sim_bus_wait_ctrl.sv
module sim_bus_wait_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [4:0]  cfg_wdata = '0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic        cpu_word = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_idle, cpu_ready, bus_strb, bus_we, bus_dvalid;
    logic [15:0] cpu_rdata, bus_wdata, bus_rdata;
    logic [2:0]  bus_sel;
    logic [1:0]  bus_be;
    logic [23:0] bus_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // slave: read data depends only on the presented address
    assign bus_rdata = {bus_addr[7:0] ^ 8'h3C, bus_addr[15:8] + 8'h01};

    bus_wait_ctrl u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_word(cpu_word), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_idle(cpu_idle), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_sel(bus_sel), .bus_strb(bus_strb), .bus_we(bus_we),
        .bus_be(bus_be), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_dvalid(bus_dvalid), .bus_rdata(bus_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_w [2];
    int          m_h [2];
    int          m_strb, m_hold, m_reg;
    logic [23:0] m_addr;
    logic        m_we, m_word;
    logic [15:0] m_wd;

    function automatic int region_of(logic [23:0] a);
        if (a < 24'h040000) return 0;
        if (a >= 24'hFF0000) return 1;
        return 2;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_w[0] = 7; m_w[1] = 7; m_h[0] = 3; m_h[1] = 3;
            m_strb = 0; m_hold = 0; m_reg = 0;
            m_addr = '0; m_we = 0; m_word = 0; m_wd = '0;
        end else begin
            if (m_strb == 0 && m_hold == 0) begin
                if (cpu_req) begin
                    m_addr = cpu_addr; m_we = cpu_we; m_word = cpu_word;
                    m_wd = cpu_wdata; m_reg = region_of(cpu_addr);
                    m_strb = (m_reg < 2 ? m_w[m_reg] : 0) + 1;
                    m_hold = (m_reg < 2 ? m_h[m_reg] : 0);
                end
            end else if (m_strb > 0) begin
                m_strb--;
            end else begin
                m_hold--;
            end
            if (cfg_wr && cfg_sel < 2) begin
                m_w[cfg_sel] = int'(cfg_wdata[2:0]);
                m_h[cfg_sel] = int'(cfg_wdata[4:3]);
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [23:0] e_addr;
            logic [15:0] e_rd, raw;
            logic        e_strb, e_ready;
            e_strb  = m_strb > 0;
            e_ready = m_strb == 1;
            e_addr  = m_word ? {m_addr[23:1], 1'b0} : m_addr;
            raw     = {e_addr[7:0] ^ 8'h3C, e_addr[15:8] + 8'h01};
            e_rd    = m_word ? raw : {8'h00, (e_addr[0] ? raw[15:8] : raw[7:0])};
            check("R2 strobe", bus_strb, e_strb);
            check("R4 idle", cpu_idle, (m_strb == 0 && m_hold == 0));
            check("R3 ready", cpu_ready, e_ready);
            check("R3 dvalid", bus_dvalid, e_ready);
            check("R1 sel", bus_sel, e_strb ? (3'b001 << m_reg) : 3'b000);
            if (e_strb) begin
                check("R10 addr", bus_addr, e_addr);
                check("R10 we", bus_we, m_we);
                check("R8 be", bus_be, m_word ? 2'b11 : (e_addr[0] ? 2'b10 : 2'b01));
                if (m_we)
                    check("R8 wdata", bus_wdata, m_word ? m_wd : {2{m_wd[7:0]}});
            end
            check("R9 rdata", cpu_rdata, (e_ready && !m_we) ? e_rd : 16'h0);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cfg_write(input logic [1:0] sel, input logic [4:0] data);
        @(negedge clk);
        cfg_wr = 1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic access(input logic [23:0] addr, input logic we, input logic word,
                          input logic [15:0] wd, input int exp_w, input int exp_h,
                          input bit keep_busy, input bit c_en, input logic [1:0] c_sel,
                          input logic [4:0] c_data, input string tag);
        int strobes = 0;
        int holds = 0;
        @(negedge clk);
        while (!cpu_idle) @(negedge clk);
        cpu_req = 1; cpu_addr = addr; cpu_we = we; cpu_word = word; cpu_wdata = wd;
        cfg_wr = c_en; cfg_sel = c_sel; cfg_wdata = c_data;
        @(negedge clk);
        cfg_wr = 0;
        forever begin
            if (bus_strb) strobes++;
            else if (!cpu_idle) holds++;
            else break;
            cpu_req = keep_busy;
            if (keep_busy) begin cpu_addr = 24'h123457; cpu_we = ~we; end
            @(negedge clk);
        end
        cpu_req = 0;
        check({tag, " wait cycles"}, strobes, exp_w + 1);
        check({tag, " hold cycles"}, holds, exp_h);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R6: reset state
        check("R6 idle after reset", cpu_idle, 1);
        check("R6 strobe after reset", bus_strb, 0);
        // R6: slowest counts after reset in both timed regions
        access(24'h000100, 0, 1, 16'h0, 7, 3, 0, 0, 0, 0, "R6 pmem reset timing");
        access(24'hFF0011, 1, 0, 16'hA5C3, 7, 3, 0, 0, 0, 0, "R6 io reset timing");
        // R2: general region has no wait and no hold
        access(24'h500000, 0, 0, 16'h0, 0, 0, 0, 0, 0, 0, "R2 general region");
        // R5: program memory wait 2 hold 1; I/O unchanged
        cfg_write(2'd0, 5'b01_010);
        access(24'h000201, 0, 0, 16'h0, 2, 1, 0, 0, 0, 0, "R8 pmem byte read");
        access(24'hFF0020, 0, 0, 16'h0, 7, 3, 0, 0, 0, 0, "R5 io separate");
        cfg_write(2'd1, 5'b00_000);
        access(24'hFF0033, 0, 1, 16'h0, 0, 0, 0, 0, 0, 0, "R9 io odd word read");
        access(24'hFF0034, 1, 1, 16'hBEEF, 0, 0, 0, 0, 0, 0, "R9 io word write");
        // R5: selects 2 and 3 are ignored
        cfg_write(2'd2, 5'b00_000);
        cfg_write(2'd3, 5'b11_111);
        access(24'h03FFFF, 1, 0, 16'h0077, 2, 1, 0, 0, 0, 0, "R5 ignored sel pmem");
        access(24'hFF0000, 0, 0, 16'h0, 0, 0, 0, 0, 0, 0, "R5 ignored sel io");
        // R1: window edges
        access(24'h040000, 0, 1, 16'h0, 0, 0, 0, 0, 0, 0, "R1 above pmem");
        access(24'hFEFFFF, 0, 0, 16'h0, 0, 0, 0, 0, 0, 0, "R1 below io");
        // R7: write at the acceptance edge does not affect this access
        access(24'h000400, 0, 1, 16'h0, 2, 1, 0, 1, 2'd0, 5'b10_110, "R7 same-edge write");
        access(24'h000402, 0, 1, 16'h0, 6, 2, 0, 0, 0, 0, "R7 next access");
        // R11: request held high while busy is ignored
        access(24'h000010, 1, 1, 16'h1234, 6, 2, 1, 0, 0, 0, "R11 busy request");
        @(negedge clk);
        check("R11 no extra access", bus_strb, 0);
        // R3/R4: zero wait with maximum hold, back to back
        cfg_write(2'd0, 5'b11_000);
        access(24'h000021, 1, 0, 16'h00C9, 0, 3, 0, 0, 0, 0, "R4 zero wait max hold");
        access(24'h000022, 0, 0, 16'h0, 0, 3, 0, 0, 0, 0, "R3 zero wait read");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule